// File: doc/BRIEF.md
# Serial Configuration Sequencer

This block is a master for the slave-serial configuration port of a programmable target device. On a start request it holds the target's program-request pin low for a fixed time and releases it. It then waits, within a bounded time, for the target to report that it is ready to accept data. Next it shifts a stream of payload bytes out one bit at a time, each bit with its own configuration-clock pulse. After the payload it keeps pulsing the configuration clock until the target reports that configuration is complete.

Payload bytes arrive on a valid/ready stream that also carries an error line from the byte source. The byte count is captured when the start request is accepted. The half-period of the configuration clock is an input, so one instance can serve fast and slow targets. Both wait phases have timeouts. The block reports its result on three flags: busy, done and error.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `prog_b_o` is 1 while `cclk_o` and `din_o` are both 0. After reset, `busy_o`, `done_o` and `error_o` are all 0.
- R2: A start request accepted while idle drives `prog_b_o` low for exactly PROG_LOW_CYCLES clock cycles and then returns it high.
- R3: If the synchronised ready input stays low for INIT_WAIT_MAX cycles after the program pin is released, the sequencer sets `error_o`, returns to idle and produces no configuration-clock pulse.
- R4: Each payload byte is sent most significant bit first. `din_o` changes only while `cclk_o` is low and holds steady for the whole high phase, and the target samples it on the rising edge.
- R5: Exactly `byte_count_i` bytes are taken from the source. A byte is transferred in each cycle in which `s_ready_o` and `s_valid_i` are both 1.
- R6: Each high phase and each low phase of the configuration clock inside a byte or the trailing pulse train lasts max(1, `half_period_i`) clock cycles. A value of 0 behaves like 1.
- R7: After the payload, pulses continue until the synchronised completion input is seen high. The sequencer then sets `done_o`, leaves `error_o` at 0 and returns to idle.
- R8: If the completion input has not been seen high after DONE_PULSE_MAX trailing pulses, the sequencer sets `error_o` and returns to idle. In that case the target sees exactly 8·N + DONE_PULSE_MAX rising clock edges in total, where N is the byte count.
- R9: If `s_error_i` is 1 while the sequencer is waiting for a byte, the transfer stops. The sequencer sets `error_o`, returns to idle and produces no further clock pulse.
- R10: `error_o` and `done_o` stay set while idle and are both cleared when the next start request is accepted.
- R11: A start request while busy has no effect: the program pin is not pulsed again and the running transfer completes normally.
- R12: With a byte count of 0, no byte is taken from the source and the sequencer goes directly from the ready wait to the trailing pulse train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| byte_count_i | input | LEN_W | Number of payload bytes, captured at start |
| half_period_i | input | PHASE_W | Clock cycles per configuration-clock phase (0 behaves like 1) |
| s_valid_i | input | 1 | Payload byte available |
| s_data_i | input | 8 | Payload byte |
| s_error_i | input | 1 | Byte source failure |
| s_ready_o | output | 1 | Sequencer accepts a byte |
| init_b_i | input | 1 | Target ready for data (asynchronous, pulled up) |
| done_pin_i | input | 1 | Target configuration complete (asynchronous, pulled up) |
| prog_b_o | output | 1 | Program request to the target, active low |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed successfully |
| error_o | output | 1 | Last sequence failed (timeout or source error) |

## Verification
A wrong sequencer state shows at the pins within one configuration-clock phase. A stuck or skipped state lengthens or truncates the program pulse. A wrong bit counter or shift register produces a wrong bit at the target's rising-edge sample within the same byte. A miscount of remaining bytes changes the number of source handshakes and the rise count at the end of the run. Timeout counters that stop one step early or late change the exact rise count seen when completion never arrives, and a lost sticky flag is visible on `error_o` in the first idle cycle after the failure.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    // Sequencer phases; the encoding carries no meaning outside the block.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT,
        ST_LOAD,
        ST_SHIFT,
        ST_FLUSH
    } seq_state_e;

endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchroniser, one independent chain per input bit.
module cfg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cfg_cclk_gen.sv
// Configuration clock phase generator. Holds low while not enabled; when
// enabled, alternates low and high phases of max(1, half_i) cycles each and
// flags the last cycle of each high phase.
module cfg_cclk_gen #(
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               stop_i,
    input  logic [PHASE_W-1:0] half_i,
    output logic               cclk_o,
    output logic               bit_end_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] cnt;
        logic               hi;
    } gen_state_t;

    gen_state_t q, d;
    logic [PHASE_W-1:0] last;

    always_comb begin
        last = (half_i == '0) ? '0 : half_i - 1'b1;
        bit_end_o = en_i && q.hi && (q.cnt == last);
        d = q;
        if (stop_i) begin
            d.cnt = '0;
            d.hi  = 1'b0;
        end else if (en_i) begin
            if (q.cnt >= last) begin
                d.cnt = '0;
                d.hi  = !q.hi;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, hi: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cclk_o = q.hi;

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_seq_pkg::*;
#(
    parameter int unsigned LEN_W           = 24,
    parameter int unsigned PHASE_W         = 8,
    parameter int unsigned PROG_LOW_CYCLES = 6250000,
    parameter int unsigned INIT_WAIT_MAX   = 100000,
    parameter int unsigned DONE_PULSE_MAX  = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   byte_count_i,
    input  logic [PHASE_W-1:0] half_period_i,
    input  logic               s_valid_i,
    input  logic [7:0]         s_data_i,
    input  logic               s_error_i,
    output logic               s_ready_o,
    input  logic               init_b_i,
    input  logic               done_pin_i,
    output logic               prog_b_o,
    output logic               cclk_o,
    output logic               din_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o
);

    localparam int unsigned MAX_AB   = (PROG_LOW_CYCLES > INIT_WAIT_MAX) ? PROG_LOW_CYCLES : INIT_WAIT_MAX;
    localparam int unsigned WAIT_MAX = (MAX_AB > DONE_PULSE_MAX) ? MAX_AB : DONE_PULSE_MAX;
    localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] PROG_LAST  = WAIT_W'(PROG_LOW_CYCLES - 1);
    localparam logic [WAIT_W-1:0] INIT_LAST  = WAIT_W'(INIT_WAIT_MAX - 1);
    localparam logic [WAIT_W-1:0] FLUSH_LAST = WAIT_W'(DONE_PULSE_MAX - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [LEN_W-1:0]  remain;
        logic [7:0]        shreg;
        logic [2:0]        bit_idx;
        logic [WAIT_W-1:0] wait_cnt;
        logic              prog_b;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic [1:0] pins_s;
    logic       init_s, done_s;
    logic       run_now, run_next, bit_end;

    cfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_pin_i, init_b_i}),
        .sync_o  (pins_s)
    );
    assign init_s = pins_s[0];
    assign done_s = pins_s[1];

    assign run_now = (q.state == ST_SHIFT) || (q.state == ST_FLUSH);

    cfg_cclk_gen #(.PHASE_W(PHASE_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (run_now),
        .stop_i    (!run_next),
        .half_i    (half_period_i),
        .cclk_o    (cclk_o),
        .bit_end_o (bit_end)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.done     = 1'b0;
                    d.err      = 1'b0;
                    d.remain   = byte_count_i;
                    d.wait_cnt = '0;
                    d.state    = ST_PROG;
                end
            end
            ST_PROG: begin
                if (q.wait_cnt == PROG_LAST) begin
                    d.wait_cnt = '0;
                    d.state    = ST_INIT;
                end else begin
                    d.wait_cnt = q.wait_cnt + 1'b1;
                end
            end
            ST_INIT: begin
                if (init_s) begin
                    d.wait_cnt = '0;
                    d.state    = (q.remain == '0) ? ST_FLUSH : ST_LOAD;
                end else if (q.wait_cnt == INIT_LAST) begin
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.wait_cnt = q.wait_cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                if (s_error_i) begin
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end else if (s_valid_i) begin
                    d.shreg   = s_data_i;
                    d.bit_idx = '0;
                    d.remain  = q.remain - 1'b1;
                    d.state   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_end) begin
                    d.shreg   = {q.shreg[6:0], 1'b0};
                    d.bit_idx = q.bit_idx + 1'b1;
                    if (q.bit_idx == 3'd7) begin
                        d.wait_cnt = '0;
                        d.state    = (q.remain == '0) ? ST_FLUSH : ST_LOAD;
                    end
                end
            end
            ST_FLUSH: begin
                if (done_s) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else if (bit_end) begin
                    if (q.wait_cnt == FLUSH_LAST) begin
                        d.err   = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.wait_cnt = q.wait_cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (d.state == ST_IDLE) begin
            d.shreg = '0;
        end
        d.prog_b = (d.state != ST_PROG);
        run_next = (d.state == ST_SHIFT) || (d.state == ST_FLUSH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, remain: '0, shreg: '0, bit_idx: '0,
                   wait_cnt: '0, prog_b: 1'b1, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign s_ready_o = (q.state == ST_LOAD);
    assign prog_b_o  = q.prog_b;
    assign din_o     = q.shreg[7];
    assign busy_o    = (q.state != ST_IDLE);
    assign done_o    = q.done;
    assign error_o   = q.err;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic s_ready_o,
    input logic prog_b_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic done_o,
    input logic error_o
);

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (prog_b_o && !cclk_o && !din_o));

    a_r2_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_b_o |-> (busy_o && !cclk_o && !s_ready_o));

    a_r4_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> $stable(din_o));

    a_r5_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (busy_o && !cclk_o));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!done_o && !error_o));

endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .s_ready_o (s_ready_o),
    .prog_b_o  (prog_b_o),
    .cclk_o    (cclk_o),
    .din_o     (din_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o)
);

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;

    localparam int LEN_W      = 16;
    localparam int PHASE_W    = 4;
    localparam int PROG_LOW   = 20;
    localparam int INIT_MAX   = 40;
    localparam int DONE_MAX   = 30;
    localparam int INIT_DLY   = 10;

    // vector: byte count, half period, extra pulses before completion, seed
    localparam int NVEC = 5;
    localparam int VEC [NVEC][4] = '{
        '{3, 1, 2, 17},
        '{1, 3, 0, 5},
        '{4, 0, 5, 99},
        '{0, 2, 3, 1},
        '{2, 2, 1, 42}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] byte_count_i = '0;
    logic [PHASE_W-1:0] half_period_i = '0;
    logic s_valid_i, s_error_i, s_ready_o;
    logic [7:0] s_data_i;
    logic init_b = 1'b1;
    logic done_pin = 1'b0;
    logic prog_b_o, cclk_o, din_o, busy_o, done_o, error_o;

    always #4 clk = !clk;

    cfg_loader #(
        .LEN_W(LEN_W), .PHASE_W(PHASE_W), .PROG_LOW_CYCLES(PROG_LOW),
        .INIT_WAIT_MAX(INIT_MAX), .DONE_PULSE_MAX(DONE_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .half_period_i(half_period_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
        .s_error_i(s_error_i), .s_ready_o(s_ready_o), .init_b_i(init_b),
        .done_pin_i(done_pin), .prog_b_o(prog_b_o), .cclk_o(cclk_o), .din_o(din_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // target and source controls, driven only from the initial block
    bit init_never = 1'b0;
    bit done_never = 1'b0;
    int done_at = 0;
    int src_len = 0;
    int src_seed = 0;
    int err_at = -1;

    // target model state, driven only from the model block
    logic cclk_d = 1'b0;
    logic prog_d = 1'b1;
    int rises = 0;
    int prog_low_len = 0;
    int prog_low_last = 0;
    int prog_falls = 0;
    int init_cnt = 0;
    int hi_run = 0, lo_run = 0;
    int hi_min = 999, hi_max = 0, lo_min = 999;
    int src_idx = 0;
    bit rx_bits [0:255];

    function automatic logic [7:0] gen_byte(int seed, int idx);
        int v;
        v = seed * 37 + idx * 73 + 90;
        return 8'(v) ^ 8'(idx << 4);
    endfunction

    assign s_valid_i = (src_idx < src_len) && (src_idx != err_at);
    assign s_error_i = (src_idx == err_at);
    assign s_data_i  = gen_byte(src_seed, src_idx);

    always @(posedge clk) begin
        cclk_d <= cclk_o;
        prog_d <= prog_b_o;
        if (!prog_b_o) begin
            init_b   <= 1'b0;
            init_cnt <= 0;
            done_pin <= 1'b0;
            rises    <= 0;
            src_idx  <= 0;
            prog_low_len <= prog_low_len + 1;
            if (prog_d) begin
                prog_falls <= prog_falls + 1;
                hi_min <= 999;
                hi_max <= 0;
                lo_min <= 999;
            end
        end else begin
            if (!prog_d) begin
                prog_low_last <= prog_low_len;
                prog_low_len  <= 0;
            end
            if (!init_never && !init_b) begin
                init_cnt <= init_cnt + 1;
                if (init_cnt == INIT_DLY) init_b <= 1'b1;
            end
            if (s_ready_o && s_valid_i) src_idx <= src_idx + 1;
            if (cclk_o && !cclk_d) begin
                if (rises < 256) rx_bits[rises] <= din_o;
                rises <= rises + 1;
                if (!done_never && (rises + 1 >= done_at)) done_pin <= 1'b1;
            end
        end
        if (cclk_o) begin
            hi_run <= hi_run + 1;
        end else begin
            if (cclk_d && busy_o) begin
                if (hi_run < hi_min) hi_min <= hi_run;
                if (hi_run > hi_max) hi_max <= hi_run;
            end
            hi_run <= 0;
        end
        if (!cclk_o) begin
            lo_run <= lo_run + 1;
        end else begin
            if (!cclk_d && rises > 0 && lo_run < lo_min) lo_min <= lo_run;
            lo_run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        int n = 0;
        while (busy_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(!busy_o, "R7 sequence ends", busy_o, 0);
    endtask

    task automatic launch(input int n, input int half, input int extra, input int seed);
        @(negedge clk);
        src_len = n;
        src_seed = seed;
        done_at = 8 * n + extra;
        byte_count_i = LEN_W'(n);
        half_period_i = PHASE_W'(half);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_payload(input int n, input string req);
        int bad = 0;
        for (int k = 0; k < 8 * n; k++) begin
            logic [7:0] b;
            b = gen_byte(src_seed, k / 8);
            if (rx_bits[k] != b[7 - (k % 8)]) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_idle_pins(input string req);
        check(prog_b_o && !cclk_o && !din_o, req,
              {29'd0, prog_b_o, cclk_o, din_o}, 4);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        check_idle_pins("R1 reset pins");
        check(!busy_o && !done_o && !error_o, "R1 reset flags",
              {29'd0, busy_o, done_o, error_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int eff;
            eff = (VEC[v][1] == 0) ? 1 : VEC[v][1];
            launch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            finish_run();
            check(done_o && !error_o, "R7 done flag", {30'd0, done_o, error_o}, 2);
            check(prog_low_last == PROG_LOW, "R2 program pulse width", prog_low_last, PROG_LOW);
            check(src_idx == VEC[v][0], (VEC[v][0] == 0) ? "R12 zero count handshakes" : "R5 handshakes",
                  src_idx, VEC[v][0]);
            check(rises >= 8 * VEC[v][0] + VEC[v][2], "R7 trailing pulses", rises,
                  8 * VEC[v][0] + VEC[v][2]);
            check_payload(VEC[v][0], "R4 payload bits");
            check(hi_min == eff && hi_max == eff, "R6 high phase", hi_max, eff);
            check(lo_min == eff, "R6 low phase", lo_min, eff);
            check_idle_pins("R1 idle pins after run");
        end

        // R3 ready never arrives
        init_never = 1'b1;
        launch(2, 1, 0, 3);
        finish_run();
        check(error_o && !done_o, "R3 init timeout error", error_o, 1);
        check(rises == 0, "R3 no clock pulses", rises, 0);
        init_never = 1'b0;
        // R10 sticky error
        repeat (10) @(negedge clk);
        check(error_o, "R10 error sticky", error_o, 1);

        // R10 start clears, then R8 completion never arrives
        launch(1, 1, 0, 8);
        finish_run();
        check(done_o && !error_o, "R10 cleared by start", error_o, 0);
        done_never = 1'b1;
        launch(1, 1, 0, 8);
        finish_run();
        check(error_o && !done_o, "R8 completion timeout", error_o, 1);
        check(rises == 8 + DONE_MAX, "R8 exact pulse count", rises, 8 + DONE_MAX);
        done_never = 1'b0;

        // R9 source error after one byte
        err_at = 1;
        launch(3, 1, 0, 21);
        finish_run();
        check(error_o && !done_o, "R9 source error flag", error_o, 1);
        check(rises == 8, "R9 transfer stopped", rises, 8);
        check(src_idx == 1, "R9 bytes taken", src_idx, 1);
        check_idle_pins("R1 idle pins after abort");
        err_at = -1;

        // R11 start while busy ignored
        begin
            int falls0;
            falls0 = prog_falls;
            launch(2, 2, 1, 63);
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            finish_run();
            check(prog_falls - falls0 == 1, "R11 single program pulse", prog_falls - falls0, 1);
            check(done_o && !error_o, "R11 run completes", done_o, 1);
            check_payload(2, "R11 payload intact");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule